// File: doc/BRIEF.md
# Relocating Wishbone Single-Transfer Master

This block sits behind a bus-target front end. It turns one captured dword request into exactly one Wishbone classic cycle on a local bus. The front end reports an address hit, then gives a one-cycle write or read start together with the dword offset inside a 16 MB window, the write data and active-low byte enables. The block forms a 32-bit dword address by placing a 10-bit relocation register above the window offset. With this, the window can sit anywhere in the local space.

Every transfer follows the same fixed sequence. First comes a setup cycle with the strobes low. Next is one cycle that raises CYC and STB. The block then waits for the acknowledge for at most sixteen cycles, and ends with a finishing cycle that drops the strobes and raises a one-cycle done pulse. If no acknowledge comes, the transfer still completes. The timeout flag is raised, the local address is logged in a failed-address register that the host can read, and for reads the bus data is sampled anyway. A two-state requester asks for the local bus from the address hit until the transfer finishes. The local clock and reset outputs are taken straight from the block's own clock and reset.

Top module: `wbm_reloc_master`

## Requirements
- R1: The local address is {relocation register, window offset}: relocation bits 9:0 go to address bits 31:22 and offset bits 23:2 go to address bits 21:0. The relocation register resets to 0 and is loaded by `reloc_we_i`.
- R2: Each accepted start produces exactly one CYC assertion. Address, data and select are already driven in the setup cycle before CYC rises, and they stay steady until the done cycle.
- R3: CYC and STB rise together and fall together. WE is high during CYC only for writes. The done pulse comes in the cycle right after CYC falls.
- R4: After the access cycle, the wait lasts until ACK is high, or for at most 16 cycles, so CYC is high for 1+N cycles when ACK comes in wait cycle N (1..16) and for 17 cycles when it never comes. An ACK in the 16th wait cycle counts as an acknowledge, not a timeout.
- R5: When the wait ends by timeout, `fail_addr_o` takes the local address of that transfer. It changes at no other time, and it resets to 0.
- R6: For a read, `rdata_o` takes `lb_dat_i` at the end of the wait, on acknowledge and on timeout alike.
- R7: `lb_sel_o` is the bitwise inverse of the `be_n_i` captured at the start.
- R8: `lb_req_o` rises in the cycle after `hit_i` is sampled high. It stays high, with or without a transfer, until the cycle after the done pulse, where it is 0.
- R9: `lb_clk_o` follows `clk_i`, and `lb_rst_o` is the inverse of `rst_n_i`.
- R10: If write and read starts arrive together while the block is idle, one write cycle runs and the read is dropped.
- R11: A start, hit or address change that arrives while a transfer is running has no effect on that transfer and starts no further cycle.
- R12: `soft_rst_i` returns the sequencer to idle, drops the request and clears the wait counter. It does not clear `fail_addr_o`.
- R13: `done_o` is high for exactly one cycle per transfer. `tout_o` is high only in that cycle, and only if the wait timed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous sequencer reset |
| reloc_we_i | input | 1 | Load strobe for the relocation register |
| reloc_din_i | input | 10 | New relocation value |
| hit_i | input | 1 | Memory-space address hit from the front end |
| wr_start_i | input | 1 | Write start pulse |
| rd_start_i | input | 1 | Read start pulse |
| win_addr_i | input | 22 | Dword offset inside the window (byte address bits 23:2) |
| wdata_i | input | 32 | Write data |
| be_n_i | input | 4 | Active-low byte enables |
| rdata_o | output | 32 | Read holding register |
| done_o | output | 1 | One-cycle completion pulse |
| tout_o | output | 1 | Timeout flag, valid with done_o |
| fail_addr_o | output | 32 | Local address of the last timed-out transfer |
| lb_clk_o | output | 1 | Local bus clock |
| lb_rst_o | output | 1 | Local bus reset, active high |
| lb_req_o | output | 1 | Local bus request |
| lb_cyc_o | output | 1 | Wishbone CYC |
| lb_stb_o | output | 1 | Wishbone STB |
| lb_we_o | output | 1 | Wishbone WE |
| lb_adr_o | output | 32 | Wishbone dword address |
| lb_sel_o | output | 4 | Wishbone byte selects |
| lb_dat_o | output | 32 | Wishbone write data |
| lb_dat_i | input | 32 | Wishbone read data |
| lb_ack_i | input | 1 | Wishbone acknowledge |

## Verification
Transfers are run with the acknowledge in the first wait cycle, in the 15th and in the 16th, and with no acknowledge at all. This separates a correct timeout limit from an off-by-one limit, and it checks that an acknowledge arriving together with the limit is not taken as a timeout. The relocation values and offsets include all zeros, all ones and alternating bits, so a shifted or truncated concatenation cannot pass. Reads and writes alternate so that both the select inversion and the failed-address log are seen with each direction. Directed cases cover simultaneous starts, a start injected mid-transfer, a soft reset during the wait followed by a full-length timeout, and a hit that comes with no transfer.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_ACCESS = 3'd2,
    PH_WAIT   = 3'd3,
    PH_FINISH = 3'd4
  } phase_e;

  typedef enum logic {
    RQ_OFF = 1'b0,
    RQ_ON  = 1'b1
  } req_e;

endpackage

// File: rtl/wbm_phase_seq.sv
module wbm_phase_seq
  import wbm_pkg::*;
#(
  parameter int TMO_W = 4
) (
  input  logic   clk_i,
  input  logic   rst_n_i,
  input  logic   soft_rst_i,
  input  logic   wr_start_i,
  input  logic   rd_start_i,
  input  logic   ack_i,
  output phase_e phase_o,
  output logic   launch_o,
  output logic   launch_wr_o,
  output logic   wait_end_o,
  output logic   wait_tout_o
);

  localparam logic [TMO_W-1:0] TMO_LAST = {TMO_W{1'b1}};

  phase_e            ph_q, ph_d;
  logic [TMO_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic              in_wait;
  logic              limit;

  // accept decisions
  always_comb begin
    launch_o    = (ph_q == PH_IDLE) && (wr_start_i || rd_start_i) && !soft_rst_i;
    launch_wr_o = launch_o && wr_start_i;
    in_wait     = (ph_q == PH_WAIT) && !soft_rst_i;
    limit       = (cnt_q == TMO_LAST);
    wait_end_o  = in_wait && (ack_i || limit);
    wait_tout_o = in_wait && !ack_i && limit;
  end

  // next phase
  always_comb begin
    ph_d = ph_q;
    if (soft_rst_i) begin
      ph_d = PH_IDLE;
    end else begin
      case (ph_q)
        PH_IDLE:   if (launch_o) ph_d = PH_SETUP;
        PH_SETUP:  ph_d = PH_ACCESS;
        PH_ACCESS: ph_d = PH_WAIT;
        PH_WAIT:   if (wait_end_o) ph_d = PH_FINISH;
        PH_FINISH: ph_d = PH_IDLE;
        default:   ph_d = PH_IDLE;
      endcase
    end
  end

  // wait counter: cleared while entering the wait, counting inside it
  always_comb begin
    cnt_en = soft_rst_i || (ph_q == PH_ACCESS) || (ph_q == PH_WAIT);
    if (soft_rst_i || (ph_q != PH_WAIT)) cnt_d = '0;
    else                                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign phase_o = ph_q;

endmodule

// File: rtl/wbm_req_ctl.sv
module wbm_req_ctl
  import wbm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic soft_rst_i,
  input  logic hit_i,
  input  logic finish_i,
  output logic req_o
);

  req_e rq_q, rq_d;

  always_comb begin
    rq_d = rq_q;
    if (soft_rst_i) begin
      rq_d = RQ_OFF;
    end else begin
      case (rq_q)
        RQ_OFF:  if (hit_i && !finish_i) rq_d = RQ_ON;
        RQ_ON:   if (finish_i) rq_d = RQ_OFF;
        default: rq_d = RQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rq_q <= RQ_OFF;
    else          rq_q <= rq_d;
  end

  assign req_o = (rq_q == RQ_ON);

endmodule

// File: rtl/wbm_xfer_regs.sv
module wbm_xfer_regs #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WIN_W = 24,
  localparam int RELOC_W = AW - (WIN_W - 2),
  localparam int SEL_W   = DW / 8
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               reloc_we_i,
  input  logic [RELOC_W-1:0] reloc_din_i,
  input  logic               launch_i,
  input  logic               launch_wr_i,
  input  logic [WIN_W-1:2]   win_addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [SEL_W-1:0]   be_n_i,
  input  logic               wait_end_i,
  input  logic               wait_tout_i,
  input  logic [DW-1:0]      lb_dat_i,
  output logic [AW-1:0]      cap_adr_o,
  output logic [DW-1:0]      cap_dat_o,
  output logic [SEL_W-1:0]   cap_sel_o,
  output logic               cap_wr_o,
  output logic [DW-1:0]      rdata_o,
  output logic [AW-1:0]      fail_addr_o,
  output logic               tout_flag_o
);

  logic [RELOC_W-1:0] reloc_q;
  logic [AW-1:0]      adr_q, adr_d;
  logic [DW-1:0]      dat_q, rd_q;
  logic [SEL_W-1:0]   sel_q, sel_d;
  logic               wr_q, tfl_q;
  logic [AW-1:0]      fail_q;
  logic               rd_en;

  always_comb begin
    adr_d = {reloc_q, win_addr_i};
    sel_d = ~be_n_i;
    rd_en = wait_end_i && !wr_q;
  end

  // relocation register
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)        reloc_q <= '0;
    else if (reloc_we_i) reloc_q <= reloc_din_i;
  end

  // request capture
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      adr_q <= '0;
      dat_q <= '0;
      sel_q <= '0;
      wr_q  <= 1'b0;
    end else if (launch_i) begin
      adr_q <= adr_d;
      dat_q <= wdata_i;
      sel_q <= sel_d;
      wr_q  <= launch_wr_i;
    end
  end

  // read holding register
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)   rd_q <= '0;
    else if (rd_en) rd_q <= lb_dat_i;
  end

  // completion status and failure log
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      tfl_q  <= 1'b0;
      fail_q <= '0;
    end else begin
      if (wait_end_i)  tfl_q  <= wait_tout_i;
      if (wait_tout_i) fail_q <= adr_q;
    end
  end

  assign cap_adr_o   = adr_q;
  assign cap_dat_o   = dat_q;
  assign cap_sel_o   = sel_q;
  assign cap_wr_o    = wr_q;
  assign rdata_o     = rd_q;
  assign fail_addr_o = fail_q;
  assign tout_flag_o = tfl_q;

endmodule

// File: rtl/wbm_reloc_master.sv
module wbm_reloc_master
  import wbm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WIN_W = 24,
  parameter int TMO_W = 4,
  localparam int RELOC_W = AW - (WIN_W - 2),
  localparam int SEL_W   = DW / 8
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               soft_rst_i,
  input  logic               reloc_we_i,
  input  logic [RELOC_W-1:0] reloc_din_i,
  input  logic               hit_i,
  input  logic               wr_start_i,
  input  logic               rd_start_i,
  input  logic [WIN_W-1:2]   win_addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [SEL_W-1:0]   be_n_i,
  output logic [DW-1:0]      rdata_o,
  output logic               done_o,
  output logic               tout_o,
  output logic [AW-1:0]      fail_addr_o,
  output logic               lb_clk_o,
  output logic               lb_rst_o,
  output logic               lb_req_o,
  output logic               lb_cyc_o,
  output logic               lb_stb_o,
  output logic               lb_we_o,
  output logic [AW-1:0]      lb_adr_o,
  output logic [SEL_W-1:0]   lb_sel_o,
  output logic [DW-1:0]      lb_dat_o,
  input  logic [DW-1:0]      lb_dat_i,
  input  logic               lb_ack_i
);

  phase_e             phase;
  logic               launch, launch_wr, wait_end, wait_tout;
  logic [AW-1:0]      cap_adr;
  logic [DW-1:0]      cap_dat;
  logic [SEL_W-1:0]   cap_sel;
  logic               cap_wr, tout_flag;
  logic               busy, active, finish;

  wbm_phase_seq #(.TMO_W(TMO_W)) u_seq (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .soft_rst_i  (soft_rst_i),
    .wr_start_i  (wr_start_i),
    .rd_start_i  (rd_start_i),
    .ack_i       (lb_ack_i),
    .phase_o     (phase),
    .launch_o    (launch),
    .launch_wr_o (launch_wr),
    .wait_end_o  (wait_end),
    .wait_tout_o (wait_tout)
  );

  wbm_xfer_regs #(.AW(AW), .DW(DW), .WIN_W(WIN_W)) u_regs (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .reloc_we_i  (reloc_we_i),
    .reloc_din_i (reloc_din_i),
    .launch_i    (launch),
    .launch_wr_i (launch_wr),
    .win_addr_i  (win_addr_i),
    .wdata_i     (wdata_i),
    .be_n_i      (be_n_i),
    .wait_end_i  (wait_end),
    .wait_tout_i (wait_tout),
    .lb_dat_i    (lb_dat_i),
    .cap_adr_o   (cap_adr),
    .cap_dat_o   (cap_dat),
    .cap_sel_o   (cap_sel),
    .cap_wr_o    (cap_wr),
    .rdata_o     (rdata_o),
    .fail_addr_o (fail_addr_o),
    .tout_flag_o (tout_flag)
  );

  wbm_req_ctl u_req (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .soft_rst_i (soft_rst_i),
    .hit_i      (hit_i),
    .finish_i   (finish),
    .req_o      (lb_req_o)
  );

  always_comb begin
    busy     = (phase != PH_IDLE);
    active   = (phase == PH_ACCESS) || (phase == PH_WAIT);
    finish   = (phase == PH_FINISH);
    lb_cyc_o = active;
    lb_stb_o = active;
    lb_we_o  = active && cap_wr;
    lb_adr_o = busy ? cap_adr : '0;
    lb_sel_o = busy ? cap_sel : '0;
    lb_dat_o = (busy && cap_wr) ? cap_dat : '0;
    done_o   = finish;
    tout_o   = finish && tout_flag;
  end

  assign lb_clk_o = clk_i;
  assign lb_rst_o = ~rst_n_i;

endmodule

module wbm_reloc_master_chk #(
  parameter int AW    = 32,
  parameter int TMO_W = 4
) (
  input logic          clk_i,
  input logic          rst_n_i,
  input logic          soft_rst_i,
  input logic          lb_cyc_o,
  input logic [AW-1:0] lb_adr_o,
  input logic          lb_req_o,
  input logic          done_o,
  input logic          tout_o,
  input logic [AW-1:0] fail_addr_o
);

  localparam int RUN_MAX = 1 << TMO_W;
  localparam int RUN_W   = TMO_W + 2;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)      run_q <= '0;
    else if (lb_cyc_o) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  AST_SETUP_BEFORE_CYC: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(lb_cyc_o) |-> $stable(lb_adr_o)); // R2
  AST_ADR_HELD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (lb_cyc_o && $past(lb_cyc_o)) |-> $stable(lb_adr_o)); // R2
  AST_DONE_AFTER_CYC: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |-> ($past(lb_cyc_o) && !lb_cyc_o)); // R3
  AST_CYC_END_DONE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(lb_cyc_o) |-> (done_o || $past(soft_rst_i))); // R3
  AST_CYC_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    lb_cyc_o |-> (int'(run_q) <= RUN_MAX)); // R4
  AST_FAIL_LOGGED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (done_o && tout_o) |-> (fail_addr_o == lb_adr_o)); // R5
  AST_FAIL_ONLY_TOUT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !$stable(fail_addr_o) |-> (done_o && tout_o)); // R5
  AST_REQ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |=> !lb_req_o); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |=> !done_o); // R13

endmodule

bind wbm_reloc_master wbm_reloc_master_chk #(.AW(AW), .TMO_W(TMO_W)) u_chk (
  .clk_i       (clk_i),
  .rst_n_i     (rst_n_i),
  .soft_rst_i  (soft_rst_i),
  .lb_cyc_o    (lb_cyc_o),
  .lb_adr_o    (lb_adr_o),
  .lb_req_o    (lb_req_o),
  .done_o      (done_o),
  .tout_o      (tout_o),
  .fail_addr_o (fail_addr_o)
);

// File: tb/wbm_reloc_master_test.sv
module wbm_reloc_master_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        soft_rst, reloc_we, hit, wr_start, rd_start;
  logic [9:0]  reloc_din;
  logic [23:2] win_addr;
  logic [31:0] wdata, rd_bus;
  logic [3:0]  be_n;
  logic [31:0] rdata, fail_addr, adr, dat_o;
  logic        done, tout, lclk, lrst, req, cyc, stb, we, ack;
  logic [3:0]  sel;

  always #4 clk = ~clk;

  wbm_reloc_master uut (
    .clk_i(clk), .rst_n_i(rst_n), .soft_rst_i(soft_rst),
    .reloc_we_i(reloc_we), .reloc_din_i(reloc_din), .hit_i(hit),
    .wr_start_i(wr_start), .rd_start_i(rd_start), .win_addr_i(win_addr),
    .wdata_i(wdata), .be_n_i(be_n), .rdata_o(rdata), .done_o(done),
    .tout_o(tout), .fail_addr_o(fail_addr), .lb_clk_o(lclk), .lb_rst_o(lrst),
    .lb_req_o(req), .lb_cyc_o(cyc), .lb_stb_o(stb), .lb_we_o(we),
    .lb_adr_o(adr), .lb_sel_o(sel), .lb_dat_o(dat_o), .lb_dat_i(rd_bus),
    .lb_ack_i(ack)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // slave: ack in the stb cycle whose index equals slv_delay (0 = never)
  int slv_delay = 0;
  int slv_idx = 0;
  always @(negedge clk) begin
    if (cyc) begin
      ack     <= (slv_delay != 0) && (slv_idx == slv_delay);
      slv_idx <= slv_idx + 1;
    end else begin
      ack     <= 1'b0;
      slv_idx <= 0;
    end
  end

  typedef struct packed {
    logic        wr;
    logic [9:0]  reloc;
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be_n;
    logic [4:0]  delay;
    logic [31:0] exp_adr;
    logic        exp_tout;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{1'b1, 10'h000, 32'h0000_0010, 32'hA5A5_0001, 4'h0, 5'd1,  32'h0000_0004, 1'b0},
    '{1'b0, 10'h3FF, 32'hFFFF_FFFC, 32'h1234_5678, 4'h0, 5'd3,  32'hFFFF_FFFF, 1'b0},
    '{1'b1, 10'h155, 32'h12AB_CDE8, 32'hDEAD_BEEF, 4'hA, 5'd16, 32'h556A_F37A, 1'b0},
    '{1'b0, 10'h2C0, 32'h0080_0004, 32'hCAFE_F00D, 4'h3, 5'd0,  32'hB020_0001, 1'b1},
    '{1'b1, 10'h001, 32'h00FF_FFFC, 32'h0BAD_F00D, 4'hE, 5'd15, 32'h007F_FFFF, 1'b0},
    '{1'b1, 10'h200, 32'h0000_0100, 32'h7777_0000, 4'h5, 5'd0,  32'h8000_0040, 1'b1},
    '{1'b0, 10'h000, 32'h0000_0000, 32'h8765_4321, 4'h7, 5'd2,  32'h0000_0000, 1'b0}
  };

  // observations of one transfer
  int          o_len, o_rises, o_extra;
  logic        o_we_any, o_we_all, o_done, o_tout, o_req_setup, o_req_done;
  logic        o_req_after, o_done_after;
  logic [31:0] o_adr_setup, o_adr_first, o_adr_done, o_dat, o_rdata;
  logic [3:0]  o_sel;

  task automatic load_reloc(input logic [9:0] v);
    @(negedge clk);
    reloc_we  = 1'b1;
    reloc_din = v;
    @(negedge clk);
    reloc_we  = 1'b0;
  endtask

  task automatic do_xfer(input logic w, input logic r, input logic h,
                         input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] bn, input int dly, input int inj_at);
    logic prev;
    o_len = 0; o_rises = 0; o_extra = 0; o_we_any = 0; o_we_all = 1;
    o_done = 0; o_tout = 0; prev = 0;
    @(negedge clk);
    slv_delay = dly;
    wr_start = w; rd_start = r; hit = h;
    win_addr = a[23:2]; wdata = d; be_n = bn;
    if (!w) rd_bus = d; else rd_bus = ~d;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      wr_start = 1'b0; rd_start = 1'b0; hit = 1'b0;
      if (i == 0) begin
        o_req_setup = req;
        o_adr_setup = adr;
      end
      if (cyc) begin
        if (!prev) begin
          o_rises++;
          o_adr_first = adr;
        end
        o_len++;
        o_we_any = o_we_any | we;
        o_we_all = o_we_all & we;
        o_dat = dat_o;
        o_sel = sel;
      end
      prev = cyc;
      if (done) begin
        o_done = 1; o_tout = tout; o_rdata = rdata;
        o_adr_done = adr; o_req_done = req;
        break;
      end
      if (inj_at != 0 && o_len == inj_at) begin
        rd_start = 1'b1; hit = 1'b1; win_addr = 22'h2A_5A5A;
        wdata = 32'h0;
      end
    end
    @(negedge clk);
    o_req_after  = req;
    o_done_after = done;
    repeat (4) begin
      @(negedge clk);
      if (cyc) o_extra++;
    end
  endtask

  logic [31:0] exp_fail;

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not end actual=%h expected=%h", 32'h1, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; soft_rst = 0; reloc_we = 0; reloc_din = '0; hit = 0;
    wr_start = 0; rd_start = 0; win_addr = '0; wdata = '0; be_n = '0;
    rd_bus = '0;
    exp_fail = 32'h0;
    repeat (3) @(negedge clk);
    // reset state
    chk("R9 local reset high in reset", {31'h0, lrst}, 32'h1);
    chk("R3 cyc low in reset", {31'h0, cyc}, 32'h0);
    chk("R8 request low in reset", {31'h0, req}, 32'h0);
    chk("R13 done low in reset", {31'h0, done}, 32'h0);
    chk("R5 fail address reset", fail_addr, 32'h0);
    chk("R6 read register reset", rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 local reset released", {31'h0, lrst}, 32'h0);
    chk("R9 local clock low at negedge", {31'h0, lclk}, 32'h0);
    @(posedge clk); #1;
    chk("R9 local clock high after posedge", {31'h0, lclk}, 32'h1);

    // relocation register resets to 0
    do_xfer(1'b1, 1'b0, 1'b1, 32'h0000_0040, 32'h1111_2222, 4'h0, 2, 0);
    chk("R1 reset relocation value", o_adr_done, 32'h0000_0010);

    // vector table
    foreach (VECS[k]) begin
      load_reloc(VECS[k].reloc);
      do_xfer(VECS[k].wr, !VECS[k].wr, 1'b1, VECS[k].addr, VECS[k].data,
              VECS[k].be_n, int'(VECS[k].delay), 0);
      if (VECS[k].exp_tout) exp_fail = VECS[k].exp_adr;
      chk($sformatf("R1 address v%0d", k), o_adr_done, VECS[k].exp_adr);
      chk($sformatf("R2 setup address v%0d", k), o_adr_setup, VECS[k].exp_adr);
      chk($sformatf("R2 first cyc address v%0d", k), o_adr_first, VECS[k].exp_adr);
      chk($sformatf("R2 single cycle v%0d", k), o_rises + o_extra, 32'd1);
      chk($sformatf("R3 we v%0d", k), {31'h0, o_we_any}, {31'h0, VECS[k].wr});
      chk($sformatf("R4 cyc length v%0d", k), o_len,
          VECS[k].exp_tout ? 32'd17 : 32'(VECS[k].delay) + 32'd1);
      chk($sformatf("R13 done and tout v%0d", k), {30'h0, o_done, o_tout},
          {30'h0, 1'b1, VECS[k].exp_tout});
      chk($sformatf("R5 fail address v%0d", k), fail_addr, exp_fail);
      chk($sformatf("R7 select v%0d", k), {28'h0, o_sel}, {28'h0, ~VECS[k].be_n});
      if (VECS[k].wr)
        chk($sformatf("R2 write data v%0d", k), o_dat, VECS[k].data);
      else
        chk($sformatf("R6 read data v%0d", k), o_rdata, VECS[k].data);
      chk($sformatf("R8 request seq v%0d", k), {29'h0, o_req_setup, o_req_done, o_req_after},
          32'h6);
      chk($sformatf("R13 done one cycle v%0d", k), {31'h0, o_done_after}, 32'h0);
    end

    // R10: simultaneous starts, write wins, read dropped
    load_reloc(10'h0F0);
    do_xfer(1'b1, 1'b1, 1'b1, 32'h0000_0020, 32'h5A5A_A5A5, 4'h0, 2, 0);
    chk("R10 one cycle for both starts", o_rises + o_extra, 32'd1);
    chk("R10 write won", {30'h0, o_we_all, o_we_any}, 32'h3);
    chk("R10 write data driven", o_dat, 32'h5A5A_A5A5);

    // R11: start during a running transfer is ignored
    do_xfer(1'b1, 1'b0, 1'b1, 32'h0000_0030, 32'h0F0F_0F0F, 4'h0, 6, 3);
    chk("R11 address unchanged", o_adr_done, 32'h3C00_000C);
    chk("R11 still a write", {31'h0, o_we_all}, 32'h1);
    chk("R11 no second cycle", o_rises + o_extra, 32'd1);
    chk("R11 data unchanged", o_dat, 32'h0F0F_0F0F);

    // R12: soft reset in the wait phase
    slv_delay = 0;
    @(negedge clk);
    rd_start = 1'b1; hit = 1'b1; win_addr = 22'h00_0100;
    @(negedge clk);
    rd_start = 1'b0; hit = 1'b0;
    repeat (6) @(negedge clk);
    chk("R12 transfer running before soft reset", {31'h0, cyc}, 32'h1);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R12 cyc dropped", {31'h0, cyc}, 32'h0);
    chk("R12 request dropped", {31'h0, req}, 32'h0);
    chk("R12 no done", {31'h0, done}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R12 still idle", {30'h0, cyc, done}, 32'h0);
    chk("R12 fail address kept", fail_addr, exp_fail);
    do_xfer(1'b0, 1'b1, 1'b1, 32'h0000_0200, 32'h4444_5555, 4'h0, 0, 0);
    chk("R12 counter cleared, full timeout", o_len, 32'd17);
    chk("R5 fail address after soft reset", fail_addr, 32'h3C00_0080);

    // R8: hit without any transfer
    @(negedge clk);
    hit = 1'b1;
    @(negedge clk);
    hit = 1'b0;
    chk("R8 request after hit", {31'h0, req}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R8 request held without transfer", {30'h0, req, cyc}, 32'h2);
    do_xfer(1'b1, 1'b0, 1'b0, 32'h0000_0004, 32'h0000_0001, 4'h0, 1, 0);
    chk("R8 request released by transfer", {31'h0, o_req_after}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule